// File: doc/BRIEF.md
# Ethernet Destination-Address Receive Filter

This block decides, for each received Ethernet frame, whether the frame is accepted, using only its 48-bit destination address. Three mechanisms work together. A 4096-bit hash table catches wanted multicast groups. A small exact-match table lists wanted unicast stations. A control word holds accept-all switches for broadcast, unicast and multicast traffic. The control word also selects which 12-bit window of the address forms the hash index.

Software configures the block through three plain write ports: one for the control word, one for 32-bit hash words, and one for exact-match entries. The receive path presents a destination address with a valid strobe. One clock later the block returns an accept flag, a code giving the reason for the decision, and the index of the exact-match entry that fired. Address byte 0, the first byte on the wire, sits in bits 7:0 of the address ports, and byte 5 sits in bits 47:40.

Top module: `mcf_rx_filter`

## Requirements
- R1: A synchronous reset clears the control word, the whole hash table and every entry valid bit. Until software configures the block, every lookup, broadcast included, returns accept 0 and source 0.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. Back-to-back strobes give back-to-back results. While `out_valid` is low, `out_accept`, `out_src` and `out_idx` are all zero.
- R3: An all-ones address is a broadcast. It is accepted with source 1 only when control bit 0 is set. Otherwise it is rejected, whatever the other control bits are.
- R4: The 12-bit hash index is picked by the offset mode in control bits 6:5: mode 0 takes address bits 47:36, mode 1 takes bits 46:35, mode 2 takes bits 45:34 and mode 3 takes bits 43:32.
- R5: The hash table is 128 words of 32 bits. Index bits 11:5 select the word and bits 4:0 select the bit within it. A write to a word replaces all 32 of its bits.
- R6: A multicast address is one with address bit 0 set that is not a broadcast. Such an address is accepted with source 3 when control bit 4 is set and its hash bit is set.
- R7: A unicast address (address bit 0 clear) that equals a valid exact-match entry is accepted with source 2 when control bit 3 is set. `out_idx` gives the lowest-numbered matching entry. Multicast addresses never match the exact-match table.
- R8: An exact-match entry written with an all-zero address is stored as not valid, even if the write asks for valid.
- R9: With control bit 1 set, a unicast address that finds no exact match is accepted with source 4. An exact match still reports source 2.
- R10: With control bit 2 set, a multicast address that finds no hash hit is accepted with source 4.
- R11: A rejected lookup returns accept 0, source 0 and index 0. `out_idx` is also 0 for every source other than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Control word. Bit 0: broadcast accept. Bit 1: unicast accept-all. Bit 2: multicast accept-all. Bit 3: exact-match enable. Bit 4: hash enable. Bits 6:5: offset mode |
| hash_we | input | 1 | Write strobe for one hash word |
| hash_waddr | input | 7 | Index of the hash word to write |
| hash_wdata | input | 32 | New contents of the hash word |
| ent_we | input | 1 | Write strobe for one exact-match entry |
| ent_idx | input | 4 | Index of the entry to write |
| ent_addr | input | 48 | Station address to store in the entry |
| ent_valid | input | 1 | Requested valid state of the entry |
| in_valid | input | 1 | Lookup strobe |
| in_addr | input | 48 | Destination address to classify |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_accept | output | 1 | Frame accepted |
| out_src | output | 3 | Reason for the decision: 0 reject, 1 broadcast, 2 exact, 3 hash, 4 promiscuous |
| out_idx | output | 4 | Matching exact-match entry when the source is 2 |

## Verification
A wrong hash window, a wrong word or bit select, or a hash word that only partly updates shows up as an accept or a reject that differs from the prediction. The error appears on the first lookup of an address chosen to land on a known bit, one cycle after the strobe. An entry valid bit in the wrong state, or a priority encoder that picks the wrong entry, shows up in `out_src` and `out_idx` on the next lookup of a duplicated address. Precedence faults show up in the same cycle as a wrong source code. Examples are broadcast falling through to multicast, or an accept-all switch overriding an exact match. A control or reset fault shows up as a wrong answer on the very first lookup after reset.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

  typedef enum logic [2:0] {
    SRC_REJECT  = 3'd0,
    SRC_BCAST   = 3'd1,
    SRC_EXACT   = 3'd2,
    SRC_HASH    = 3'd3,
    SRC_PROMISC = 3'd4
  } src_e;

  // control word image, bits 6:0
  typedef struct packed {
    logic [1:0] mode;        // 6:5 hash window offset
    logic       hash_en;     // 4
    logic       exact_en;    // 3
    logic       mc_all;      // 2
    logic       uc_all;      // 1
    logic       bcast_en;    // 0
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  function automatic logic [11:0] hash_index(input logic [47:0] a, input logic [1:0] mode);
    case (mode)
      2'd0:    hash_index = a[47:36];
      2'd1:    hash_index = a[46:35];
      2'd2:    hash_index = a[45:34];
      default: hash_index = a[43:32];
    endcase
  endfunction

  function automatic logic is_bcast(input logic [47:0] a);
    is_bcast = &a;
  endfunction

  function automatic logic is_group(input logic [47:0] a);
    is_group = a[0];
  endfunction

endpackage

// File: rtl/mcf_hash_table.sv
module mcf_hash_table #(
  parameter int IDX_W  = 12,
  parameter int WORD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-$clog2(WORD_W)-1:0] wr_word,
  input  logic [WORD_W-1:0]    wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic                 rd_hit
);
  localparam int BIT_W   = $clog2(WORD_W);
  localparam int WADDR_W = IDX_W - BIT_W;
  localparam int N_WORDS = 1 << WADDR_W;

  logic [WORD_W-1:0] words [N_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < N_WORDS; w++) words[w] <= '0;
    end else if (wr_en) begin
      words[wr_word] <= wr_data;
    end
  end

  logic [WADDR_W-1:0] sel_word;
  logic [BIT_W-1:0]   sel_bit;
  assign sel_word = rd_idx[IDX_W-1:BIT_W];
  assign sel_bit  = rd_idx[BIT_W-1:0];
  assign rd_hit   = words[sel_word][sel_bit];

  // R5: a word write replaces the full word
  p_word_write_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> words[$past(wr_word)] == $past(wr_data));

endmodule

// File: rtl/mcf_exact_table.sv
module mcf_exact_table #(
  parameter int N_ENT = 16,
  parameter int AW    = 48
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(N_ENT)-1:0] wr_idx,
  input  logic [AW-1:0]            wr_addr,
  input  logic                     wr_valid,
  input  logic [AW-1:0]            key,
  output logic                     hit_any,
  output logic [$clog2(N_ENT)-1:0] hit_idx
);
  localparam int IW = $clog2(N_ENT);

  logic [AW-1:0]    ent_addr [N_ENT];
  logic [N_ENT-1:0] ent_vld;
  logic [N_ENT-1:0] hit_vec;
  logic             wr_nonzero;

  assign wr_nonzero = |wr_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
      for (int i = 0; i < N_ENT; i++) ent_addr[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N_ENT; i++) begin
        if (wr_idx == IW'(i)) begin
          ent_addr[i] <= wr_addr;
          ent_vld[i]  <= wr_valid && wr_nonzero;
        end
      end
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit_vec[g] = ent_vld[g] && (ent_addr[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IW'(i);
    end
  end
  assign hit_any = |hit_vec;

  // R7: reported entry really matches and no lower entry matches
  p_hit_lowest_r7: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> (hit_vec[hit_idx] &&
                 ((hit_vec & ((N_ENT'(1) << hit_idx) - N_ENT'(1))) == '0)));

  // R8: an all-zero address never becomes a valid entry
  p_zero_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_nonzero) |=> !ent_vld[$past(wr_idx)]);

endmodule

// File: rtl/mcf_rx_filter.sv
module mcf_rx_filter #(
  parameter int N_ENT  = 16,
  parameter int HASH_W = 12,
  parameter int WORD_W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  input  logic        hash_we,
  input  logic [6:0]  hash_waddr,
  input  logic [31:0] hash_wdata,
  input  logic        ent_we,
  input  logic [3:0]  ent_idx,
  input  logic [47:0] ent_addr,
  input  logic        ent_valid,
  input  logic        in_valid,
  input  logic [47:0] in_addr,
  output logic        out_valid,
  output logic        out_accept,
  output logic [2:0]  out_src,
  output logic [3:0]  out_idx
);
  import mcf_pkg::*;

  localparam int ENT_IW = $clog2(N_ENT);

  ctl_t ctl;

  always_ff @(posedge clk) begin
    if (rst)         ctl <= '0;
    else if (ctl_we) ctl <= ctl_t'(ctl_wdata[CTL_W-1:0]);
  end

  // classification of the incoming address
  logic              frm_bcast, frm_group;
  logic [HASH_W-1:0] h_idx;
  logic              h_hit;
  logic              x_hit;
  logic [ENT_IW-1:0] x_idx;

  assign frm_bcast = is_bcast(in_addr);
  assign frm_group = is_group(in_addr);
  assign h_idx     = hash_index(in_addr, ctl.mode);

  mcf_hash_table #(.IDX_W(HASH_W), .WORD_W(WORD_W)) u_hash (
    .clk(clk), .rst(rst),
    .wr_en(hash_we), .wr_word(hash_waddr), .wr_data(hash_wdata),
    .rd_idx(h_idx), .rd_hit(h_hit)
  );

  mcf_exact_table #(.N_ENT(N_ENT), .AW(48)) u_exact (
    .clk(clk), .rst(rst),
    .wr_en(ent_we), .wr_idx(ent_idx), .wr_addr(ent_addr), .wr_valid(ent_valid),
    .key(in_addr), .hit_any(x_hit), .hit_idx(x_idx)
  );

  src_e              dec_src;
  logic [ENT_IW-1:0] dec_idx;

  always_comb begin
    dec_src = SRC_REJECT;
    dec_idx = '0;
    if (frm_bcast) begin
      if (ctl.bcast_en) dec_src = SRC_BCAST;
    end else if (frm_group) begin
      if (ctl.hash_en && h_hit) dec_src = SRC_HASH;
      else if (ctl.mc_all)      dec_src = SRC_PROMISC;
    end else begin
      if (ctl.exact_en && x_hit) begin
        dec_src = SRC_EXACT;
        dec_idx = x_idx;
      end else if (ctl.uc_all) begin
        dec_src = SRC_PROMISC;
      end
    end
  end

  src_e              r_src;
  logic [ENT_IW-1:0] r_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_accept <= 1'b0;
      r_src      <= SRC_REJECT;
      r_idx      <= '0;
    end else begin
      out_valid  <= in_valid;
      out_accept <= in_valid && (dec_src != SRC_REJECT);
      r_src      <= in_valid ? dec_src : SRC_REJECT;
      r_idx      <= in_valid ? dec_idx : '0;
    end
  end

  assign out_src = r_src;
  assign out_idx = 4'(r_idx);

  // R1: the first result after reset is empty
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_accept && out_src == 3'd0));

  // R2: idle outputs carry no stale fields
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_accept && out_src == 3'd0 && out_idx == 4'd0));

  // R3: broadcast with its accept bit gives a broadcast result
  p_bcast_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && frm_bcast && ctl.bcast_en && !ctl_we) |=>
      (out_accept && out_src == SRC_BCAST));

  // R7: a group address never reports an exact match
  p_group_not_exact_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && frm_group) |=> (out_src != SRC_EXACT));

  // R11: a rejection carries zero fields
  p_reject_fields_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_accept) |-> (out_src == 3'd0 && out_idx == 4'd0));

endmodule

// File: tb/mcf_rx_filter_bench.sv
`timescale 1ns/1ps
module mcf_rx_filter_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        ctl_we;
  logic [31:0] ctl_wdata;
  logic        hash_we;
  logic [6:0]  hash_waddr;
  logic [31:0] hash_wdata;
  logic        ent_we;
  logic [3:0]  ent_idx;
  logic [47:0] ent_addr;
  logic        ent_valid;
  logic        in_valid;
  logic [47:0] in_addr;
  logic        out_valid;
  logic        out_accept;
  logic [2:0]  out_src;
  logic [3:0]  out_idx;

  always #2 clk = ~clk;

  mcf_rx_filter u_mcf_rx_filter (
    .clk(clk), .rst(rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .hash_we(hash_we), .hash_waddr(hash_waddr), .hash_wdata(hash_wdata),
    .ent_we(ent_we), .ent_idx(ent_idx), .ent_addr(ent_addr), .ent_valid(ent_valid),
    .in_valid(in_valid), .in_addr(in_addr),
    .out_valid(out_valid), .out_accept(out_accept), .out_src(out_src), .out_idx(out_idx)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC1 = 48'hA53C_0000_5E01;
  localparam logic [47:0] MC2 = 48'h1177_0000_5E01;
  localparam logic [47:0] UC1 = 48'h6655_4433_2210;
  localparam logic [47:0] UC2 = 48'h0102_0304_0508;

  // bench-side hash index: bytes 4 and 5 as a 16-bit value, shifted per mode
  function automatic int bidx(input logic [47:0] a, input int mode);
    int v;
    v = (int'(a[47:40]) << 8) | int'(a[39:32]);
    case (mode)
      0: return (v >> 4) & 12'hFFF;
      1: return (v >> 3) & 12'hFFF;
      2: return (v >> 2) & 12'hFFF;
      default: return v & 12'hFFF;
    endcase
  endfunction

  task automatic check(input string req, input int acc, input int src, input int idx,
                       input int e_acc, input int e_src, input int e_idx);
    total++;
    if (acc != e_acc || src != e_src || idx != e_idx) begin
      bad++;
      $display("FAIL %s: got acc=%0d src=%0d idx=%0d, expected acc=%0d src=%0d idx=%0d",
               req, acc, src, idx, e_acc, e_src, e_idx);
    end
  endtask

  task automatic set_ctl(input bit bc, input bit uc, input bit mcp, input bit ex,
                         input bit hs, input int mode);
    @(negedge clk);
    ctl_we = 1; ctl_wdata = {25'd0, 2'(mode), hs, ex, mcp, uc, bc};
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic put_word(input int w, input logic [31:0] d);
    @(negedge clk);
    hash_we = 1; hash_waddr = 7'(w); hash_wdata = d;
    @(negedge clk);
    hash_we = 0;
  endtask

  task automatic put_ent(input int i, input logic [47:0] a, input bit v);
    @(negedge clk);
    ent_we = 1; ent_idx = 4'(i); ent_addr = a; ent_valid = v;
    @(negedge clk);
    ent_we = 0;
  endtask

  task automatic look(input string req, input logic [47:0] a,
                      input int e_acc, input int e_src, input int e_idx);
    @(negedge clk);
    in_valid = 1; in_addr = a;
    @(negedge clk);
    in_valid = 0;
    total++;
    if (out_valid !== 1'b1) begin
      bad++;
      $display("FAIL %s: got out_valid=%0b, expected 1", req, out_valid);
    end
    check(req, int'(out_accept), int'(out_src), int'(out_idx), e_acc, e_src, e_idx);
  endtask

  task automatic t_reset;
    total++;
    if (out_valid !== 0 || out_accept !== 0 || out_src !== 0) begin
      bad++;
      $display("FAIL R1: idle outputs got v=%0b a=%0b s=%0d, expected 0", out_valid, out_accept, out_src);
    end
    look("R1 bcast after reset", BC, 0, 0, 0);
    look("R1 unicast after reset", UC1, 0, 0, 0);
    look("R1 multicast after reset", MC1, 0, 0, 0);
  endtask

  task automatic t_latency;
    set_ctl(1, 1, 0, 0, 0, 0);
    @(negedge clk);
    in_valid = 1; in_addr = BC;
    @(negedge clk);
    in_addr = MC2;
    check("R2 first of pair", int'(out_valid), int'(out_accept), int'(out_src), 1, 1, 1);
    @(negedge clk);
    in_valid = 0;
    check("R2 second of pair", int'(out_valid), int'(out_accept), int'(out_src), 1, 0, 0);
    @(negedge clk);
    check("R2 idle after pair", int'(out_valid), int'(out_src), int'(out_idx), 0, 0, 0);
  endtask

  task automatic t_bcast;
    set_ctl(1, 0, 0, 0, 0, 0);
    look("R3 bcast accepted", BC, 1, 1, 0);
    // R3: no fall-through to multicast accept-all
    set_ctl(0, 1, 1, 1, 1, 0);
    look("R3 bcast rejected without its bit", BC, 0, 0, 0);
  endtask

  task automatic t_hash_modes;
    for (int m = 0; m < 4; m++) begin
      int ix;
      ix = bidx(MC1, m);
      for (int w = 0; w < 128; w++) put_word(w, 32'd0);
      put_word(ix >> 5, 32'd1 << (ix & 31));
      set_ctl(0, 0, 0, 0, 1, m);
      look($sformatf("R4 R6 mode %0d hit", m), MC1, 1, 3, 0);
      look($sformatf("R4 mode %0d other address misses", m), MC2, 0, 0, 0);
      set_ctl(0, 0, 0, 0, 1, (m + 1) % 4);
      look($sformatf("R4 mode %0d bit not seen by next mode", m), MC1, 0, 0, 0);
      set_ctl(0, 0, 0, 0, 0, m);
      look($sformatf("R6 mode %0d hash disabled", m), MC1, 0, 0, 0);
    end
  endtask

  task automatic t_word_replace;
    int ix;
    ix = bidx(MC1, 0);
    set_ctl(0, 0, 0, 0, 1, 0);
    put_word(ix >> 5, 32'd1 << (ix & 31));
    look("R5 bit set", MC1, 1, 3, 0);
    put_word(ix >> 5, ~(32'd1 << (ix & 31)));
    look("R5 word rewrite clears bit", MC1, 0, 0, 0);
    put_word(ix >> 5, 32'd0);
  endtask

  task automatic t_exact;
    set_ctl(0, 0, 0, 1, 0, 0);
    put_ent(7, UC1, 1);
    put_ent(3, UC1, 1);
    look("R7 lowest of two matches", UC1, 1, 2, 3);
    look("R7 unknown unicast rejected", UC2, 0, 0, 0);
    put_ent(3, UC1, 0);
    look("R7 next match after invalidate", UC1, 1, 2, 7);
    put_ent(15, MC2, 1);
    look("R7 multicast never exact", MC2, 0, 0, 0);
    set_ctl(0, 0, 0, 0, 0, 0);
    look("R7 exact disabled", UC1, 0, 0, 0);
  endtask

  task automatic t_zero;
    set_ctl(0, 0, 0, 1, 0, 0);
    put_ent(0, 48'd0, 1);
    look("R8 zero address not valid", 48'd0, 0, 0, 0);
  endtask

  task automatic t_promisc;
    set_ctl(0, 1, 0, 1, 0, 0);
    look("R9 unknown unicast promiscuous", UC2, 1, 4, 0);
    look("R9 exact wins over promiscuous", UC1, 1, 2, 7);
    look("R9 no effect on multicast", MC1, 0, 0, 0);
    set_ctl(0, 0, 1, 0, 0, 0);
    look("R10 multicast promiscuous", MC2, 1, 4, 0);
    look("R10 no effect on unicast", UC2, 0, 0, 0);
    look("R11 reject fields", UC1, 0, 0, 0);
  endtask

  initial begin
    rst = 1; ctl_we = 0; ctl_wdata = 0; hash_we = 0; hash_waddr = 0; hash_wdata = 0;
    ent_we = 0; ent_idx = 0; ent_addr = 0; ent_valid = 0; in_valid = 0; in_addr = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_latency();
    t_bcast();
    t_hash_modes();
    t_word_replace();
    t_exact();
    t_zero();
    t_promisc();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule